// File: doc/BRIEF.md
# Serial Line Decoder with Stuffed-Bit Removal

This block is the receive-side front end of a full-speed serial bus analyzer. Each cycle with a bit strobe it takes one line level, already sampled at the recovered bit rate, and turns it back into a data bit. A line level equal to the one seen at the previous bit time means a one. A change of level means a zero.

The transmitter inserts a zero after each run of six ones so that the line keeps changing. The decoder counts consecutive decoded ones. It removes the bit that follows a full run: that bit gets no output strobe. If the removed bit decodes as a one, the block pulses an error flag.

A sync-clear input restarts the decoder at each packet start. It sets the remembered level back to the idle high level and clears the run count. All outputs are registered and appear one clock after the strobe.

Top module: `nrzi_destuff`

## Requirements
- R1: A strobed line level equal to the previous strobed level (or to the idle level 1 after reset or sync-clear) produces `dout`=1.
- R2: A strobed line level different from the previous strobed level produces `dout`=0.
- R3: The strobed bit that follows six consecutive decoded ones is dropped: `dout_vld` stays 0 for it.
- R4: If that dropped bit decodes as 1, `stuff_err` is 1 for exactly one cycle, one clock after its strobe, and never together with `dout_vld`.
- R5: After a dropped bit the run count restarts from zero, so the next drop needs six more decoded ones.
- R6: A decoded 0 clears the run count, so runs of five ones separated by zeros are never dropped.
- R7: `sync_clr` sets the remembered level to 1 and clears the run count; a strobe in the same cycle is ignored, and no `dout_vld` or `stuff_err` follows it.
- R8: While `rst` is high, and in the cycle after it, `dout_vld`=0, `stuff_err`=0 and `dout`=0; the remembered level starts at 1.
- R9: `dout_vld` is a single-cycle pulse one clock after each accepted strobe; no pulse appears without a strobe, and idle cycles between strobes do not change the decoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_clr | input | 1 | Restart decoding state at packet start |
| line_bit | input | 1 | Sampled line level |
| line_vld | input | 1 | Strobe: `line_bit` holds a new bit time |
| dout | output | 1 | Decoded data bit |
| dout_vld | output | 1 | One-cycle strobe for `dout` |
| stuff_err | output | 1 | One-cycle pulse: the stuffed bit decoded as 1 |

## Verification
The assertions check on every cycle the invariants that need no history of line levels. A `dout_vld` pulse must come from a strobe one clock earlier that was not cleared. The error flag never coincides with valid data and never lasts two cycles. A sync-clear is followed by a quiet cycle. The run count never passes six.

The bench's scenarios must show the rest. These are the decoded values themselves, the exact bit position where a stuffed bit is dropped, the restart of the run after a drop or a zero, and the return to the idle level after sync-clear or reset. A behavioural reference model covers them all and is compared against the outputs on every clock.

// File: rtl/nrzi_destuff_pkg.sv
package nrzi_destuff_pkg;
  localparam int  RUN_LEN_DEF  = 6;
  localparam logic IDLE_LVL_DEF = 1'b1;

  function automatic int cnt_width(input int run_len);
    return (run_len < 1) ? 1 : $clog2(run_len + 1);
  endfunction
endpackage

// File: rtl/nrzi_level_tracker.sv
module nrzi_level_tracker #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic strobe,
  input  logic line_bit,
  output logic bit_dec
);
  logic prev_lvl;

  always_ff @(posedge clk) begin
    if (rst || clr)   prev_lvl <= IDLE_LVL;
    else if (strobe)  prev_lvl <= line_bit;
  end

  // no transition decodes as one, transition as zero
  assign bit_dec = ~(line_bit ^ prev_lvl);
endmodule

// File: rtl/destuff_counter.sv
module destuff_counter #(
  parameter int RUN_LEN = nrzi_destuff_pkg::RUN_LEN_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic strobe,
  input  logic bit_in,
  output logic drop
);
  localparam int CW = nrzi_destuff_pkg::cnt_width(RUN_LEN);

  generate
    if (RUN_LEN > 0) begin : g_count
      logic [CW-1:0] run_cnt;
      assign drop = (run_cnt == CW'(RUN_LEN));

      always_ff @(posedge clk) begin
        if (rst || clr)            run_cnt <= '0;
        else if (strobe) begin
          if (drop || !bit_in)     run_cnt <= '0;
          else                     run_cnt <= run_cnt + 1'b1;
        end
      end

      AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= CW'(RUN_LEN)); // R3
      AST_RESTART_AFTER_DROP: assert property (@(posedge clk) disable iff (rst)
        (strobe && drop && !clr) |=> (run_cnt == '0)); // R5
    end else begin : g_nostuff
      assign drop = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/nrzi_destuff.sv
module nrzi_destuff #(
  parameter int   RUN_LEN  = nrzi_destuff_pkg::RUN_LEN_DEF,
  parameter logic IDLE_LVL = nrzi_destuff_pkg::IDLE_LVL_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_clr,
  input  logic line_bit,
  input  logic line_vld,
  output logic dout,
  output logic dout_vld,
  output logic stuff_err
);
  logic bit_dec;
  logic drop;
  logic take;

  assign take = line_vld && !sync_clr;

  nrzi_level_tracker #(.IDLE_LVL(IDLE_LVL)) u_lvl (
    .clk(clk), .rst(rst), .clr(sync_clr), .strobe(line_vld),
    .line_bit(line_bit), .bit_dec(bit_dec)
  );

  destuff_counter #(.RUN_LEN(RUN_LEN)) u_cnt (
    .clk(clk), .rst(rst), .clr(sync_clr), .strobe(line_vld),
    .bit_in(bit_dec), .drop(drop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout      <= 1'b0;
      dout_vld  <= 1'b0;
      stuff_err <= 1'b0;
    end else begin
      dout_vld  <= take && !drop;
      stuff_err <= take && drop && bit_dec;
      if (take && !drop) dout <= bit_dec;
    end
  end

  AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (rst)
    dout_vld |-> ($past(line_vld) && !$past(sync_clr))); // R9
  AST_ERR_EXCL_VLD: assert property (@(posedge clk) disable iff (rst)
    !(dout_vld && stuff_err)); // R4
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stuff_err |=> !stuff_err); // R4
  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (rst)
    sync_clr |=> (!dout_vld && !stuff_err)); // R7
endmodule

// File: tb/nrzi_destuff_test.sv
module nrzi_destuff_test;
  localparam int CLK_PER = 10;
  localparam int WDOG    = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1, sync_clr = 1'b0, line_bit = 1'b1, line_vld = 1'b0;
  logic dout, dout_vld, stuff_err;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R8";

  // reference model state
  int   m_run = 0;
  logic m_prev = 1'b1;
  logic e_vld = 1'b0, e_err = 1'b0, e_dout = 1'b0;
  logic tx_lvl = 1'b1;
  int   tx_run = 0;

  always #(CLK_PER/2) clk = ~clk;

  nrzi_destuff uut (
    .clk(clk), .rst(rst), .sync_clr(sync_clr), .line_bit(line_bit),
    .line_vld(line_vld), .dout(dout), .dout_vld(dout_vld), .stuff_err(stuff_err)
  );

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      errors++; checks++;
      $display("FAIL watchdog %s: actual=%0d cycles expected<=%0d", cur_req, cycles, WDOG);
      finish_run();
    end
  end

  // one clock: drive at negedge, model, compare at following negedge
  task automatic cyc(input logic r, input logic c, input logic v, input logic b);
    logic dec;
    rst = r; sync_clr = c; line_vld = v; line_bit = b;
    e_vld = 1'b0; e_err = 1'b0;
    if (r) begin
      m_prev = 1'b1; m_run = 0; e_dout = 1'b0;
    end else if (c) begin
      m_prev = 1'b1; m_run = 0;
    end else if (v) begin
      dec = (b == m_prev);
      m_prev = b;
      if (m_run == 6) begin
        m_run = 0; e_err = dec;
      end else begin
        e_vld = 1'b1; e_dout = dec;
        m_run = dec ? m_run + 1 : 0;
      end
    end
    @(negedge clk);
    checks++;
    if (dout_vld !== e_vld || stuff_err !== e_err || (e_vld && dout !== e_dout)
        || (r && dout !== 1'b0)) begin
      errors++;
      $display("FAIL %s: actual vld=%b err=%b dout=%b expected vld=%b err=%b dout=%b",
               cur_req, dout_vld, stuff_err, dout, e_vld, e_err, e_dout);
    end
  endtask

  task automatic raw(input logic lvl);
    cyc(1'b0, 1'b0, 1'b1, lvl);
  endtask

  // transmit reference: stuff then encode one data bit
  task automatic tx_bit(input logic d);
    if (!d) tx_lvl = ~tx_lvl;
    raw(tx_lvl);
    tx_run = d ? tx_run + 1 : 0;
    if (tx_run == 6) begin
      tx_lvl = ~tx_lvl; tx_run = 0;
      raw(tx_lvl);
    end
  endtask

  task automatic pkt_start();
    cyc(1'b0, 1'b1, 1'b0, 1'b1);
    tx_lvl = 1'b1; tx_run = 0;
  endtask

  initial begin
    @(negedge clk);
    cur_req = "R8";
    cyc(1'b1, 1'b0, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    // R8: first bit after reset equal to idle level decodes as 1
    raw(1'b1);

    cur_req = "R1";
    pkt_start();
    raw(1'b1); raw(1'b1);
    cur_req = "R2";
    raw(1'b0); raw(1'b1); raw(1'b0); raw(1'b0);

    cur_req = "R3";
    pkt_start();
    for (int i = 0; i < 6; i++) tx_bit(1'b1);
    tx_bit(1'b0); tx_bit(1'b1);

    cur_req = "R5";
    pkt_start();
    for (int i = 0; i < 20; i++) tx_bit(1'b1);
    tx_bit(1'b0);

    cur_req = "R6";
    pkt_start();
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 5; i++) tx_bit(1'b1);
      tx_bit(1'b0);
    end

    cur_req = "R4";
    pkt_start();
    for (int i = 0; i < 9; i++) raw(1'b1);
    raw(1'b0); raw(1'b0);
    for (int i = 0; i < 8; i++) raw(1'b0);

    cur_req = "R9";
    pkt_start();
    for (int i = 0; i < 24; i++) begin
      tx_bit(((i * 7) % 5) != 0);
      for (int g = 0; g < (i % 3); g++) cyc(1'b0, 1'b0, 1'b0, ~line_bit);
    end

    cur_req = "R7";
    pkt_start();
    for (int i = 0; i < 5; i++) raw(1'b1);
    raw(1'b0);
    for (int i = 0; i < 5; i++) raw(1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b0);
    raw(1'b0); raw(1'b0); raw(1'b1);
    for (int i = 0; i < 7; i++) raw(1'b1);

    cur_req = "R8";
    for (int i = 0; i < 4; i++) raw(1'b1);
    cyc(1'b1, 1'b0, 1'b1, 1'b1);
    raw(1'b1); raw(1'b0);

    finish_run();
  end
endmodule